// File: doc/BRIEF.md
# Match-Driven Single-Edge PWM Output Stage

This block turns a cycle counter and a small bank of compare values into a set of output pins. It owns a counter that advances by one on every clock where the `tick` strobe is high. A dedicated period value sets the length of the cycle. When the counter sits at that value, the next tick returns it to zero. Each output channel has its own compare value and its own mode bit.

In PWM mode the channel's pin is low at the start of every cycle. It rises when the counter reaches the channel's compare value and stays high until the cycle wraps. The duty cycle is therefore set by the compare value and the frequency by the period value. In match mode the channel ignores the cycle boundary. It applies a two-bit action (keep, clear, set or toggle) each time the counter reaches its compare value.

Configuration goes in through a simple write port. Every register is a single word chosen by a small address. A write becomes visible to the compare logic on the following clock.

Top module: `pwm_match_unit`

## Requirements
- R1: After reset the count is 0, every output is low, and every compare value, the period value, the mode bits and the action field are 0.
- R2: On a clock with `tick` high the count goes up by one, except when the count equals the period value: then it returns to 0. With a period value of 0 the count stays at 0.
- R3: On a clock with `tick` low the count and all outputs hold their values.
- R4: The write address selects the target register. Addresses 0 to 2 hold the compare values of channels 0 to 2. Address 3 holds the period value. Address 4 holds the mode bits in bits [2:0], where bit k high puts channel k in PWM mode. Address 5 holds the action field, with bits [2k+1:2k] belonging to channel k. Channels behave independently of one another.
- R5: In PWM mode, with a compare value m where 0 < m < period, the output goes low on the tick that wraps the count to 0. It goes high on the tick that moves the count to m, so that outside the first cycle after reset the output equals (count >= m).
- R6: In PWM mode, a compare value of 0 with a non-zero period gives an output that is high through every cycle after the first wrap. A compare value at or above the period value gives an output that is never driven high.
- R7: In match mode, on the tick that moves the count to the channel's compare value, the output takes the channel's action: 00 keeps it, 01 clears it, 10 sets it, 11 inverts it. No other tick changes it.
- R8: A register write takes effect on the next clock. A compare value lowered during a cycle acts on the first later tick that reaches it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (3) | Register select |
| wr_data | input | CNT_W (32) | Write data |
| tick | input | 1 | Counter advance strobe |
| count | output | CNT_W (32) | Current cycle count |
| mat_out | output | NCH (3) | Channel output pins |

## Verification
Some properties are checked by the assertions on every clock. These are the counter's step and wrap, and the holding of count and outputs on idle clocks. For each channel they also check the forced low at the wrap, the forced high for a zero compare value, the rise at the compare point, and the set and toggle actions in match mode. Other behaviour can only be shown by the bench scenarios over whole cycles. This covers the duty shape across several cycles, an output that never rises when the compare value is at or above the period, and the keep and clear actions. It also covers a mid-cycle change of a compare value and the independence of one PWM channel next to one match channel.

// File: rtl/pwm_match_pkg.sv
package pwm_match_pkg;

   typedef enum logic [1:0] {
      ACT_KEEP = 2'b00,
      ACT_LOW  = 2'b01,
      ACT_HIGH = 2'b10,
      ACT_FLIP = 2'b11
   } match_act_e;

   // register offsets are laid out after the per-channel compare words
   function automatic int unsigned period_addr(input int unsigned nch);
      return nch;
   endfunction

   function automatic int unsigned mode_addr(input int unsigned nch);
      return nch + 1;
   endfunction

   function automatic int unsigned action_addr(input int unsigned nch);
      return nch + 2;
   endfunction

endpackage

// File: rtl/pwm_cycle_counter.sv
module pwm_cycle_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] next_count,
   output logic             at_end
);

   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      at_end     = (cnt_q == period);
      next_count = at_end ? '0 : cnt_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= next_count;
      end
   end

   assign count = cnt_q;

endmodule

// File: rtl/pwm_match_regs.sv
module pwm_match_regs
   import pwm_match_pkg::*;
#(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned NCH    = 3,
   parameter int unsigned ADDR_W = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         wr_addr,
   input  logic [CNT_W-1:0]          wr_data,
   output logic [NCH-1:0][CNT_W-1:0] match_val,
   output logic [CNT_W-1:0]          period_val,
   output logic [NCH-1:0]            pwm_mode,
   output match_act_e [NCH-1:0]      action
);

   localparam int unsigned PER_A = period_addr(NCH);
   localparam int unsigned MOD_A = mode_addr(NCH);
   localparam int unsigned ACT_A = action_addr(NCH);
   localparam int unsigned ACT_W = 2 * NCH;

   for (genvar k = 0; k < NCH; k++) begin : g_cmp
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            match_val[k] <= '0;
         end else if (wr_en && (wr_addr == ADDR_W'(k))) begin
            match_val[k] <= wr_data;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         period_val <= '0;
         pwm_mode   <= '0;
      end else if (wr_en) begin
         if (wr_addr == ADDR_W'(PER_A)) period_val <= wr_data;
         if (wr_addr == ADDR_W'(MOD_A)) pwm_mode   <= wr_data[NCH-1:0];
      end
   end

   logic [ACT_W-1:0] act_bits;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_bits <= '0;
      end else if (wr_en && (wr_addr == ADDR_W'(ACT_A))) begin
         act_bits <= wr_data[ACT_W-1:0];
      end
   end

   for (genvar k = 0; k < NCH; k++) begin : g_act
      assign action[k] = match_act_e'(act_bits[2*k +: 2]);
   end

endmodule

// File: rtl/pwm_out_channel.sv
module pwm_out_channel
   import pwm_match_pkg::*;
#(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             at_end,
   input  logic [CNT_W-1:0] next_count,
   input  logic [CNT_W-1:0] match_val,
   input  logic [CNT_W-1:0] period_val,
   input  logic             pwm_mode,
   input  match_act_e       action,
   output logic             pin
);

   logic hit;
   logic in_range;
   logic pin_q;

   always_comb begin
      hit      = (next_count == match_val);
      in_range = (match_val < period_val);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pin_q <= 1'b0;
      end else if (tick) begin
         if (pwm_mode) begin
            if (at_end) begin
               pin_q <= hit && in_range;
            end else if (hit && in_range) begin
               pin_q <= 1'b1;
            end
         end else if (hit) begin
            unique case (action)
               ACT_KEEP: pin_q <= pin_q;
               ACT_LOW:  pin_q <= 1'b0;
               ACT_HIGH: pin_q <= 1'b1;
               ACT_FLIP: pin_q <= ~pin_q;
               default:  pin_q <= pin_q;
            endcase
         end
      end
   end

   assign pin = pin_q;

endmodule

// File: rtl/pwm_match_unit.sv
module pwm_match_unit
   import pwm_match_pkg::*;
#(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned NCH    = 3,
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic              tick,
   output logic [CNT_W-1:0]  count,
   output logic [NCH-1:0]    mat_out
);

   localparam int unsigned NREG = NCH + 3;

   if (NCH < 1) begin : g_bad_nch
      $error("pwm_match_unit: NCH must be at least 1");
   end
   if ((1 << ADDR_W) < NREG) begin : g_bad_addr
      $error("pwm_match_unit: ADDR_W too narrow for the register count");
   end
   if (2 * NCH > CNT_W || NCH > CNT_W) begin : g_bad_width
      $error("pwm_match_unit: CNT_W too narrow for mode and action fields");
   end

   logic [NCH-1:0][CNT_W-1:0] match_q;
   logic [CNT_W-1:0]          period_q;
   logic [NCH-1:0]            pwm_en_q;
   match_act_e [NCH-1:0]      act_q;
   logic [CNT_W-1:0]          next_cnt;
   logic                      cyc_end;

   pwm_match_regs #(
      .CNT_W (CNT_W),
      .NCH   (NCH),
      .ADDR_W(ADDR_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .match_val (match_q),
      .period_val(period_q),
      .pwm_mode  (pwm_en_q),
      .action    (act_q)
   );

   pwm_cycle_counter #(
      .CNT_W(CNT_W)
   ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .period    (period_q),
      .count     (count),
      .next_count(next_cnt),
      .at_end    (cyc_end)
   );

   for (genvar k = 0; k < NCH; k++) begin : g_ch
      pwm_out_channel #(
         .CNT_W(CNT_W)
      ) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .tick      (tick),
         .at_end    (cyc_end),
         .next_count(next_cnt),
         .match_val (match_q[k]),
         .period_val(period_q),
         .pwm_mode  (pwm_en_q[k]),
         .action    (act_q[k]),
         .pin       (mat_out[k])
      );
   end

endmodule

// File: rtl/pwm_match_checker.sv
module pwm_match_checker
   import pwm_match_pkg::*;
#(
   parameter int unsigned CNT_W = 32,
   parameter int unsigned NCH   = 3
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      tick,
   input logic [CNT_W-1:0]          count,
   input logic [NCH-1:0]            mat_out,
   input logic [NCH-1:0][CNT_W-1:0] match_q,
   input logic [CNT_W-1:0]          period_q,
   input logic [NCH-1:0]            pwm_en_q,
   input match_act_e [NCH-1:0]      act_q
);

   logic [CNT_W-1:0] chk_next;
   assign chk_next = (count == period_q) ? '0 : CNT_W'(count + 1'b1);

   a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && count == period_q) |=> (count == '0));

   a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && count != period_q) |=> (count == CNT_W'($past(count) + 1'b1)));

   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ($stable(count) && $stable(mat_out)));

   for (genvar k = 0; k < NCH; k++) begin : g_chk
      a_r5_low_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
         (tick && pwm_en_q[k] && count == period_q && match_q[k] != '0)
         |=> !mat_out[k]);

      a_r6_zero_high: assert property (@(posedge clk) disable iff (!rst_n)
         (tick && pwm_en_q[k] && count == period_q && match_q[k] == '0
          && period_q != '0) |=> mat_out[k]);

      a_r5_rise: assert property (@(posedge clk) disable iff (!rst_n)
         (tick && pwm_en_q[k] && count != period_q && chk_next == match_q[k]
          && match_q[k] < period_q) |=> mat_out[k]);

      a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
         (tick && !pwm_en_q[k] && act_q[k] == ACT_HIGH && chk_next == match_q[k])
         |=> mat_out[k]);

      a_r7_toggle: assert property (@(posedge clk) disable iff (!rst_n)
         (tick && !pwm_en_q[k] && act_q[k] == ACT_FLIP && chk_next == match_q[k])
         |=> (mat_out[k] != $past(mat_out[k])));
   end

endmodule

bind pwm_match_unit pwm_match_checker #(
   .CNT_W(CNT_W),
   .NCH  (NCH)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick    (tick),
   .count   (count),
   .mat_out (mat_out),
   .match_q (match_q),
   .period_q(period_q),
   .pwm_en_q(pwm_en_q),
   .act_q   (act_q)
);

// File: tb/sim_pwm_match_unit.sv
module sim_pwm_match_unit;

   localparam int CLK_PERIOD = 10;
   localparam int CNT_W = 32;
   localparam int NCH = 3;
   localparam int ADDR_W = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [CNT_W-1:0]  wr_data = '0;
   logic              tick = 1'b0;
   logic [CNT_W-1:0]  count;
   logic [NCH-1:0]    mat_out;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwm_match_unit #(.CNT_W(CNT_W), .NCH(NCH), .ADDR_W(ADDR_W)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .tick(tick), .count(count), .mat_out(mat_out)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic step();
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      check("R1 count after reset", count, 0);
      check("R1 outputs after reset", 32'(mat_out), 0);
      wr(4, 32'h7);
      step();
      check("R1 period zero after reset keeps count 0", count, 0);
      check("R1 compare zero but period zero keeps PWM low", 32'(mat_out), 0);
   endtask

   task automatic t_count();
      do_reset();
      wr(3, 4);
      for (int i = 1; i <= 4; i++) begin
         step();
         check("R2 count increments", count, i);
      end
      step();
      check("R2 count wraps at period", count, 0);
      step();
      check("R2 count restarts", count, 1);
      repeat (3) @(negedge clk);
      check("R3 count holds without tick", count, 1);
   endtask

   task automatic t_pwm_duty();
      do_reset();
      wr(3, 9);
      wr(0, 3);
      wr(4, 32'h1);
      for (int i = 0; i < 25; i++) begin
         step();
         check("R5 PWM output equals count>=match", 32'(mat_out[0]), 32'(count >= 3));
      end
      while (count != 5) step();
      repeat (2) @(negedge clk);
      check("R3 outputs hold without tick", 32'(mat_out[0]), 1);
   endtask

   task automatic t_pwm_edges();
      do_reset();
      wr(3, 6);
      wr(0, 0);
      wr(1, 6);
      wr(2, 20);
      wr(4, 32'h7);
      for (int i = 0; i < 7; i++) step();
      for (int i = 0; i < 14; i++) begin
         check("R6 compare 0 stays high", 32'(mat_out[0]), 1);
         check("R6 compare equal to period stays low", 32'(mat_out[1]), 0);
         check("R6 compare above period stays low", 32'(mat_out[2]), 0);
         step();
      end
   endtask

   task automatic t_match_mode();
      do_reset();
      wr(3, 5);
      wr(1, 2);
      wr(5, 32'(2'b10) << 2);
      step();
      check("R7 no action before match", 32'(mat_out[1]), 0);
      step();
      check("R7 set action at match", 32'(mat_out[1]), 1);
      for (int i = 0; i < 6; i++) step();
      check("R7 set stays set", 32'(mat_out[1]), 1);
      wr(5, 32'(2'b00) << 2);
      while (count != 1) step();
      step();
      check("R7 keep action leaves output", 32'(mat_out[1]), 1);
      wr(5, 32'(2'b01) << 2);
      while (count != 1) step();
      step();
      check("R7 clear action at match", 32'(mat_out[1]), 0);
      wr(5, 32'(2'b11) << 2);
      while (count != 1) step();
      step();
      check("R7 toggle action first match", 32'(mat_out[1]), 1);
      step();
      check("R7 toggle holds off match", 32'(mat_out[1]), 1);
      while (count != 1) step();
      step();
      check("R7 toggle action second match", 32'(mat_out[1]), 0);
   endtask

   task automatic t_mixed();
      do_reset();
      wr(3, 7);
      wr(0, 4);
      wr(2, 1);
      wr(4, 32'h1);
      wr(5, 32'(2'b11) << 4);
      for (int i = 1; i <= 16; i++) begin
         step();
         check("R4 channel 0 PWM independent", 32'(mat_out[0]), 32'(count >= 4));
         check("R4 channel 1 untouched", 32'(mat_out[1]), 0);
         check("R4 channel 2 toggles once per cycle",
               32'(mat_out[2]), 32'((i >= 1 && i < 9) || (i >= 17)));
      end
   endtask

   task automatic t_live_write();
      do_reset();
      wr(3, 9);
      wr(0, 6);
      wr(4, 32'h1);
      step();
      check("R8 below old compare output low", 32'(mat_out[0]), 0);
      wr(0, 2);
      check("R8 write alone changes nothing", 32'(mat_out[0]), 0);
      step();
      check("R8 lowered compare acts at next reach", 32'(mat_out[0]), 1);
      check("R8 count at lowered compare", count, 2);
   endtask

   initial begin
      t_reset();
      t_count();
      t_pwm_duty();
      t_pwm_edges();
      t_match_mode();
      t_mixed();
      t_live_write();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule